// File: doc/BRIEF.md
# Dual-Buffer Ethernet Frame Receive Controller

This block takes received Ethernet frames from a byte stream, where each byte comes with a valid strobe and optional first and last markers, and stores each frame in one of two receive buffers that software reads over a simple word-wide register bus. The two buffers are called ping and pong, and each occupies a 2 KB window. The last word of each window is a status register. Its done flag is raised by hardware when a complete frame, trailing FCS included, has been written. Software releases the buffer by clearing that flag.

Frames go to ping and pong in strict alternation, and software is expected to poll the buffers in that same order. When the buffer next in line still holds an unreleased frame, the whole incoming frame is discarded and the alternation does not move on. A frame longer than the data area of a buffer is cut off at the boundary, and the buffer is still marked done. A one-cycle interrupt pulse accompanies each completion when the buffer's interrupt enable and a global enable input are both set. A build parameter removes the pong buffer, so that every frame lands in ping.

Top module: `rxpp_rx_ctrl`

## Requirements
- R1: After reset both status registers read 0, `irq_pulse` is low, and `cpu_rdata` is 0.
- R2: Byte addresses 0x1000–0x17F8 are ping data words and 0x17FC is the ping status. 0x1800–0x1FF8 are pong data words and 0x1FFC is the pong status. In a status word, bit 0 is done and bit 3 is interrupt enable, and every other bit reads 0. Reads below 0x1000 return 0.
- R3: Frame byte k is stored in data word k/4, in bits 8*(k%4)+7 down to 8*(k%4). Lanes of the final word above the last byte read 0.
- R4: When the edge that takes the byte marked last writes a frame, that buffer's done bit reads 1 from the following cycle.
- R5: Accepted frames go alternately to ping and pong, starting with ping after reset.
- R6: If the buffer next in line has done set when a frame starts, the frame is discarded. Neither buffer's data or status changes, no interrupt is raised, and the next frame again targets the same buffer.
- R7: Bytes past the first 2044 (0x7FC) of a frame are not stored, and done is still set at the end of the frame.
- R8: Writing a status word with bit 0 = 0 clears done, and writing bit 0 = 1 leaves done unchanged. Bit 3 is written and read back as the interrupt enable.
- R9: `irq_pulse` is high for exactly the one cycle in which the new done first reads 1, and only when that buffer's enable and `irq_glb_en` are both 1.
- R10: With the pong buffer disabled by parameter, every accepted frame goes to ping, and the pong status reads 0 even after it is written.
- R11: `cpu_rdata` holds the data for a read from the cycle after `cpu_rd` is sampled, and keeps it until the next read.
- R12: Bytes that arrive while no frame is open and that carry no first marker are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame (FCS end) |
| cpu_addr | input | 13 | Byte address inside the receive window |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, one cycle after the strobe |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_pulse | output | 1 | One-cycle frame-received interrupt |

## Verification
The done bit and the interrupt pulse both become visible one cycle after the edge that takes the last byte. The bench drives the stream on falling edges and samples `irq_pulse` at the first falling edge after that byte, then samples it again one cycle later to confirm the pulse has ended. Each read result appears one cycle after its strobe. The read task raises `cpu_rd` for one edge and takes `cpu_rdata` at the falling edge that follows, so each status value reflects every completion that came before it. A second instance built without the pong buffer receives the same stimulus and is checked alongside the dual-buffer instance.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
   typedef enum logic [1:0] {FS_IDLE, FS_FILL, FS_DROP} fill_state_t;
   typedef enum logic [1:0] {RK_ZERO, RK_MEM, RK_STAT} rd_kind_t;
   localparam int unsigned STAT_DONE_BIT  = 0;
   localparam int unsigned STAT_IE_BIT    = 3;
   localparam int unsigned BYTES_PER_WORD = 4;
   localparam int unsigned WORD_W         = 32;
endpackage

// File: rtl/rxpp_fill_ctrl.sv
module rxpp_fill_ctrl
   import rxpp_pkg::*;
#(
   parameter int unsigned NBUF      = 2,
   parameter int unsigned BUF_BYTES = 2048,
   localparam int unsigned CW       = $clog2(BUF_BYTES),
   localparam int unsigned WAW      = CW - 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [7:0]      in_data,
   input  logic            in_first,
   input  logic            in_last,
   input  logic [NBUF-1:0] done_vec,
   output logic [NBUF-1:0] set_vec,
   output logic            wr_en,
   output logic            wr_bank,
   output logic [WAW-1:0]  wr_word,
   output logic [1:0]      wr_lane,
   output logic [7:0]      wr_byte,
   output logic            ptr
);
   localparam int unsigned CAP = BUF_BYTES - BYTES_PER_WORD;
   localparam logic [CW-1:0] CAP_V = CW'(CAP);

   fill_state_t   state_q;
   logic          cur_bank_q;
   logic [CW-1:0] cnt_q;
   logic          start, accept_start, frame_byte, finish, bank_sel;
   logic [CW-1:0] byte_idx;

   // target buffer pointer: toggles only for a dual build
   generate
      if (NBUF == 2) begin : g_ptr_dual
         logic ptr_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      ptr_q <= 1'b0;
            else if (finish) ptr_q <= ~ptr_q;
         end
         assign ptr = ptr_q;
      end else begin : g_ptr_single
         assign ptr = 1'b0;
      end
   endgenerate

   always_comb begin
      start        = in_valid & in_first;
      accept_start = start & ~done_vec[ptr];
      frame_byte   = accept_start | (in_valid & ~in_first & (state_q == FS_FILL));
      byte_idx     = start ? '0 : cnt_q;
      bank_sel     = start ? ptr : cur_bank_q;
      finish       = frame_byte & in_last;
      wr_en        = frame_byte & (byte_idx < CAP_V);
      wr_bank      = bank_sel;
      wr_word      = byte_idx[CW-1:2];
      wr_lane      = byte_idx[1:0];
      wr_byte      = in_data;
      set_vec      = '0;
      if (finish) set_vec[bank_sel] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= FS_IDLE;
         cur_bank_q <= 1'b0;
         cnt_q      <= '0;
      end else if (start) begin
         cur_bank_q <= ptr;
         cnt_q      <= CW'(1);
         if (in_last)           state_q <= FS_IDLE;
         else if (accept_start) state_q <= FS_FILL;
         else                   state_q <= FS_DROP;
      end else if (in_valid) begin
         unique case (state_q)
            FS_FILL: begin
               if (cnt_q != CAP_V) cnt_q <= cnt_q + CW'(1);
               if (in_last) state_q <= FS_IDLE;
            end
            FS_DROP: begin
               if (in_last) state_q <= FS_IDLE;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxpp_bufstat.sv
module rxpp_bufstat (
   input  logic clk,
   input  logic rst_n,
   input  logic set_done,
   input  logic sw_wr,
   input  logic sw_done_bit,
   input  logic sw_ie_bit,
   output logic done,
   output logic ie
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done <= 1'b0;
         ie   <= 1'b0;
      end else begin
         if (sw_wr) ie <= sw_ie_bit;
         // hardware completion wins over a same-cycle software clear
         if (set_done)                  done <= 1'b1;
         else if (sw_wr && !sw_done_bit) done <= 1'b0;
      end
   end
endmodule

// File: rtl/rxpp_bank.sv
module rxpp_bank
   import rxpp_pkg::*;
#(
   parameter int unsigned WORDS = 512,
   localparam int unsigned WAW  = $clog2(WORDS),
   localparam int unsigned DATA_WORDS = WORDS - 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [WAW-1:0]    wr_word,
   input  logic [1:0]        wr_lane,
   input  logic [7:0]        wr_byte,
   input  logic              rd_en,
   input  logic [WAW-1:0]    rd_word,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem [DATA_WORDS];

   always_ff @(posedge clk) begin
      if (wr_en && (32'(wr_word) < DATA_WORDS)) begin
         if (wr_lane == 2'd0) mem[wr_word] <= {24'd0, wr_byte};
         else                 mem[wr_word][8*wr_lane +: 8] <= wr_byte;
      end
      if (rd_en && (32'(rd_word) < DATA_WORDS)) rd_data <= mem[rd_word];
   end
endmodule

// File: rtl/rxpp_rx_ctrl.sv
module rxpp_rx_ctrl
   import rxpp_pkg::*;
#(
   parameter int unsigned DUAL_BUF  = 1,
   parameter int unsigned BUF_BYTES = 2048,
   parameter int unsigned AW        = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_first,
   input  logic              in_last,
   input  logic [AW-1:0]     cpu_addr,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   input  logic              irq_glb_en,
   output logic              irq_pulse
);
   localparam int unsigned NBUF  = (DUAL_BUF != 0) ? 2 : 1;
   localparam int unsigned WORDS = BUF_BYTES / BYTES_PER_WORD;
   localparam int unsigned WAW   = $clog2(WORDS);

   // elaboration-time parameter checks
   if (BUF_BYTES != (1 << $clog2(BUF_BYTES))) begin : g_bad_size
      $error("BUF_BYTES must be a power of two");
   end
   if (AW != $clog2(BUF_BYTES) + 2) begin : g_bad_aw
      $error("AW must cover the region bit, the bank bit and one buffer");
   end
   if (DUAL_BUF > 1) begin : g_bad_dual
      $error("DUAL_BUF must be 0 or 1");
   end

   logic [NBUF-1:0]   done_vec, ie_vec, set_vec;
   logic              wr_en, wr_bank, ptr;
   logic [WAW-1:0]    wr_word;
   logic [1:0]        wr_lane;
   logic [7:0]        wr_byte;
   logic [WORD_W-1:0] bank_data [NBUF];

   // address decode
   logic           in_region, bank_a, is_stat;
   logic [WAW-1:0] word_a;
   assign in_region = cpu_addr[AW-1];
   assign bank_a    = cpu_addr[AW-2];
   assign word_a    = cpu_addr[AW-3:2];
   assign is_stat   = (word_a == WAW'(WORDS - 1));

   rxpp_fill_ctrl #(.NBUF(NBUF), .BUF_BYTES(BUF_BYTES)) u_fill (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_first(in_first), .in_last(in_last),
      .done_vec(done_vec), .set_vec(set_vec),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_word(wr_word), .wr_lane(wr_lane),
      .wr_byte(wr_byte), .ptr(ptr)
   );

   genvar b;
   generate
      for (b = 0; b < NBUF; b++) begin : g_buf
         logic sel_b;
         assign sel_b = in_region && (bank_a == 1'(b));
         rxpp_bufstat u_stat (
            .clk(clk), .rst_n(rst_n),
            .set_done(set_vec[b]),
            .sw_wr(cpu_wr && sel_b && is_stat),
            .sw_done_bit(cpu_wdata[STAT_DONE_BIT]),
            .sw_ie_bit(cpu_wdata[STAT_IE_BIT]),
            .done(done_vec[b]), .ie(ie_vec[b])
         );
         rxpp_bank #(.WORDS(WORDS)) u_bank (
            .clk(clk),
            .wr_en(wr_en && (wr_bank == 1'(b))),
            .wr_word(wr_word), .wr_lane(wr_lane), .wr_byte(wr_byte),
            .rd_en(cpu_rd && sel_b && !is_stat),
            .rd_word(word_a), .rd_data(bank_data[b])
         );
      end
   endgenerate

   // read path: one register stage, held between reads
   rd_kind_t          kind_q;
   logic              rbank_q;
   logic [WORD_W-1:0] stat_q;
   logic              bank_ok;
   assign bank_ok = (NBUF == 2) || !bank_a;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= RK_ZERO;
         rbank_q <= 1'b0;
         stat_q  <= '0;
      end else if (cpu_rd) begin
         rbank_q <= bank_a;
         stat_q  <= '0;
         if (!in_region || !bank_ok) begin
            kind_q <= RK_ZERO;
         end else if (is_stat) begin
            kind_q <= RK_STAT;
            stat_q[STAT_DONE_BIT] <= done_vec[bank_a];
            stat_q[STAT_IE_BIT]   <= ie_vec[bank_a];
         end else begin
            kind_q <= RK_MEM;
         end
      end
   end

   always_comb begin
      unique case (kind_q)
         RK_MEM:  cpu_rdata = bank_data[rbank_q];
         RK_STAT: cpu_rdata = stat_q;
         default: cpu_rdata = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_pulse <= 1'b0;
      else        irq_pulse <= (|(set_vec & ie_vec)) && irq_glb_en;
   end
endmodule

// File: rtl/rxpp_rx_ctrl_chk.sv
module rxpp_rx_ctrl_chk #(
   parameter int unsigned NBUF  = 2,
   parameter int unsigned WORDS = 512,
   localparam int unsigned WAW  = $clog2(WORDS)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_last,
   input logic            cpu_wr,
   input logic            cpu_rd,
   input logic [31:0]     cpu_rdata,
   input logic            irq_glb_en,
   input logic            irq_pulse,
   input logic [NBUF-1:0] done_vec,
   input logic            ptr,
   input logic            wr_en,
   input logic [WAW-1:0]  wr_word
);
   // R4: done only rises after an edge that took a last byte
   assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(done_vec & ~$past(done_vec))) |-> $past(in_valid && in_last));

   // R5: the target pointer moves only together with a completion
   assert_ptr_moves_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != $past(ptr)) |-> (|(done_vec & ~$past(done_vec))));

   // R7: the status word slot is never written by frame data
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_word != WAW'(WORDS - 1)));

   // R8: done falls only after a software write
   assert_clear_by_sw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(done_vec) & ~done_vec)) |-> $past(cpu_wr));

   // R9: a pulse comes with exactly one new done and needs the global enable
   assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> ($countones(done_vec & ~$past(done_vec)) == 1));
   assert_irq_glb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(irq_glb_en));

   // R11: read data holds while no read is sampled
   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cpu_rd) |-> $stable(cpu_rdata));
endmodule

bind rxpp_rx_ctrl rxpp_rx_ctrl_chk #(.NBUF(NBUF), .WORDS(WORDS)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
   .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
   .irq_glb_en(irq_glb_en), .irq_pulse(irq_pulse),
   .done_vec(done_vec), .ptr(ptr), .wr_en(wr_en), .wr_word(wr_word)
);

// File: tb/rxpp_rx_ctrl_bench.sv
`timescale 1ns/1ps
module rxpp_rx_ctrl_bench;
   localparam logic [12:0] PING_D = 13'h1000, PING_S = 13'h17FC;
   localparam logic [12:0] PONG_D = 13'h1800, PONG_S = 13'h1FFC;
   localparam int CAP = 2044;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 0, in_first = 0, in_last = 0;
   logic [7:0] in_data = 0;
   logic [12:0] cpu_addr = 0;
   logic cpu_wr = 0, cpu_rd = 0, irq_glb_en = 0;
   logic [31:0] cpu_wdata = 0;
   logic [31:0] rdata_d, rdata_s;
   logic irq_d, irq_s;

   int n_chk = 0, n_err = 0;
   int exp_ptr = 0;
   logic irq_sd, irq_ss;

   always #2.5 clk = ~clk;

   rxpp_rx_ctrl #(.DUAL_BUF(1)) u_rxpp_rx_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_first(in_first), .in_last(in_last), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_d),
      .irq_glb_en(irq_glb_en), .irq_pulse(irq_d));

   rxpp_rx_ctrl #(.DUAL_BUF(0)) u_rxpp_rx_ctrl_single (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_first(in_first), .in_last(in_last), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_s),
      .irq_glb_en(irq_glb_en), .irq_pulse(irq_s));

   function automatic logic [7:0] fbyte(int seed, int k);
      return 8'((seed * 37 + k * 11 + 5) & 255);
   endfunction

   function automatic logic [31:0] fword(int seed, int len, int w);
      logic [31:0] v = '0;
      for (int l = 0; l < 4; l++)
         if (w * 4 + l < len && w * 4 + l < CAP) v[8*l +: 8] = fbyte(seed, w * 4 + l);
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic bus_rd(input logic [12:0] a, output logic [31:0] dd, output logic [31:0] ds);
      cpu_addr = a; cpu_rd = 1;
      @(negedge clk);
      cpu_rd = 0; dd = rdata_d; ds = rdata_s;
   endtask

   task automatic bus_wr(input logic [12:0] a, input logic [31:0] v);
      cpu_addr = a; cpu_wdata = v; cpu_wr = 1;
      @(negedge clk);
      cpu_wr = 0;
   endtask

   // drives a frame; returns the interrupt outputs seen in the cycle after the last byte
   task automatic send(input int len, input int seed, input bit with_first);
      for (int k = 0; k < len; k++) begin
         in_valid = 1; in_data = fbyte(seed, k);
         in_first = with_first && (k == 0); in_last = (k == len - 1);
         @(negedge clk);
      end
      in_valid = 0; in_first = 0; in_last = 0;
      irq_sd = irq_d; irq_ss = irq_s;
      @(negedge clk);
      chk(irq_d == 0, "R9 pulse ends after one cycle", 32'(irq_d), 0);
   endtask

   task automatic check_frame(input logic [12:0] base, input bit single, input int seed,
                              input int len, input string tag);
      logic [31:0] dd, ds, got;
      int nw = ((len < CAP ? len : CAP) + 3) / 4;
      for (int w = 0; w < nw; w++) begin
         bus_rd(base + 13'(4 * w), dd, ds);
         got = single ? ds : dd;
         chk(got == fword(seed, len, w), tag, got, fword(seed, len, w));
      end
   endtask

   initial begin
      #(200000 * 5);
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      logic [31:0] dd, ds;
      logic [12:0] base;
      int lens [14] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 20, 64};

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(irq_d == 0 && irq_s == 0, "R1 irq low", 32'(irq_d), 0);
      chk(rdata_d == 0, "R1 rdata", rdata_d, 0);
      bus_rd(PING_S, dd, ds); chk(dd == 0 && ds == 0, "R1 ping status", dd, 0);
      bus_rd(PONG_S, dd, ds); chk(dd == 0, "R1 pong status", dd, 0);
      bus_rd(13'h0040, dd, ds); chk(dd == 0, "R2 below window", dd, 0);

      bus_wr(PING_S, 32'h8); bus_wr(PONG_S, 32'h8);
      irq_glb_en = 1;
      bus_rd(PING_S, dd, ds); chk(dd == 32'h8, "R8 ie readback", dd, 32'h8);

      // R3 R4 R5 sweep over lengths, buffers released after each frame
      for (int i = 0; i < 14; i++) begin
         send(lens[i], i, 1);
         chk(irq_sd == 1, "R9 pulse on completion", 32'(irq_sd), 1);
         chk(irq_ss == 1, "R10 single pulse", 32'(irq_ss), 1);
         bus_rd(exp_ptr ? PONG_S : PING_S, dd, ds);
         chk(dd == 32'h9, "R4 R5 done at target", dd, 32'h9);
         bus_rd(exp_ptr ? PING_S : PONG_S, dd, ds);
         chk(dd == 32'h8, "R5 other buffer idle", dd, 32'h8);
         base = exp_ptr ? PONG_D : PING_D;
         check_frame(base, 0, i, lens[i], "R3 packing");
         check_frame(PING_D, 1, i, lens[i], "R10 single into ping");
         bus_wr(PING_S, 32'h8); bus_wr(PONG_S, 32'h8);
         exp_ptr ^= 1;
      end
      bus_rd(PONG_S, dd, ds); chk(ds == 0, "R10 single pong reads 0", ds, 0);

      // R11 hold
      bus_rd(PING_D, dd, ds);
      repeat (3) @(negedge clk);
      chk(rdata_d == dd, "R11 rdata held", rdata_d, dd);

      // R8 write-1 no effect on clear flag
      bus_wr(PING_S, 32'h9);
      bus_rd(PING_S, dd, ds); chk(dd == 32'h8, "R8 write 1 does not set", dd, 32'h8);

      // R9 global enable off: frame to ping
      irq_glb_en = 0;
      send(6, 50, 1);
      chk(irq_sd == 0, "R9 glb off no pulse", 32'(irq_sd), 0);
      bus_rd(PING_S, dd, ds); chk(dd == 32'h9, "R4 done with glb off", dd, 32'h9);
      bus_wr(PING_S, 32'h9);
      bus_rd(PING_S, dd, ds); chk(dd == 32'h9, "R8 write 1 keeps done", dd, 32'h9);
      bus_wr(PING_S, 32'h1);
      bus_rd(PING_S, dd, ds); chk(dd == 32'h1, "R8 ie cleared done kept", dd, 32'h1);
      bus_wr(PING_S, 32'h8);
      bus_rd(PING_S, dd, ds); chk(dd == 32'h8, "R8 clear", dd, 32'h8);
      irq_glb_en = 1;

      // R9 buffer enable off: frame to pong
      bus_wr(PONG_S, 32'h0);
      send(6, 51, 1);
      chk(irq_sd == 0, "R9 ie off no pulse", 32'(irq_sd), 0);
      bus_rd(PONG_S, dd, ds); chk(dd == 32'h1, "R5 pong got frame", dd, 32'h1);
      bus_wr(PONG_S, 32'h8);

      // R6 drop while owned
      send(8, 100, 1);
      send(8, 101, 1);
      send(8, 102, 1);
      chk(irq_sd == 0, "R6 dropped no pulse", 32'(irq_sd), 0);
      check_frame(PING_D, 0, 100, 8, "R6 ping intact");
      check_frame(PONG_D, 0, 101, 8, "R6 pong intact");
      bus_rd(PING_S, dd, ds); chk(dd == 32'h9, "R6 ping status", dd, 32'h9);
      bus_wr(PONG_S, 32'h8);
      send(8, 103, 1);
      chk(irq_sd == 0, "R6 pointer held drop", 32'(irq_sd), 0);
      bus_rd(PONG_S, dd, ds); chk(dd == 32'h8, "R6 pong not used", dd, 32'h8);
      check_frame(PING_D, 0, 100, 8, "R6 ping still intact");
      bus_wr(PING_S, 32'h8);
      send(8, 104, 1);
      chk(irq_sd == 1, "R6 accepted after release", 32'(irq_sd), 1);
      check_frame(PING_D, 0, 104, 8, "R6 ping new frame");
      check_frame(PING_D, 1, 104, 8, "R10 single drop then accept");
      bus_wr(PING_S, 32'h8); bus_wr(PONG_S, 32'h8);
      bus_rd(PONG_S, dd, ds); chk(ds == 0, "R10 pong write ignored", ds, 0);

      // R12 stray bytes, pointer is at pong
      send(5, 60, 0);
      chk(irq_sd == 0, "R12 no pulse", 32'(irq_sd), 0);
      bus_rd(PONG_S, dd, ds); chk(dd == 32'h8, "R12 ignored", dd, 32'h8);

      // R7 truncation into pong
      send(2100, 7, 1);
      chk(irq_sd == 1, "R7 pulse", 32'(irq_sd), 1);
      bus_rd(PONG_S, dd, ds); chk(dd == 32'h9, "R7 done set", dd, 32'h9);
      bus_rd(PONG_D, dd, ds); chk(dd == fword(7, 2100, 0), "R7 word0", dd, fword(7, 2100, 0));
      bus_rd(PONG_D + 13'(4 * 510), dd, ds);
      chk(dd == fword(7, 2100, 510), "R7 last word", dd, fword(7, 2100, 510));
      bus_rd(PONG_D + 13'(4 * 509), dd, ds);
      chk(dd == fword(7, 2100, 509), "R7 word509", dd, fword(7, 2100, 509));

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule